// File: doc/BRIEF.md
# External Bus Window Decoder and Cycle Sequencer

This block serves external memory and peripheral accesses. It takes one access request at a time, made of an address, a direction and byte enables. It compares the upper address bits against four programmable windows, and the lowest-numbered enabled window that matches wins. An access that matches no window uses a default configuration.

Once a configuration is selected, the block sequences the bus cycle with that configuration's timing:

- an optional idle cycle when the bus type changes;
- an address latch phase, normal or lengthened with an extra address hold cycle;
- an optional delay before the command strobe;
- a read or write strobe whose length comes from an inverted wait field;
- a one-cycle done pulse;
- an optional trailing tri-state cycle.

A chip select for the matched window is driven while the strobe is active, but only if that window's select mode permits the current direction.

Each bus configuration word is 11 bits wide. The bit positions are:

- [3:0] inverted wait field;
- [4] command delay;
- [5] trailing tri-state cycle;
- [6] lengthened address latch;
- [7] chip select on writes;
- [8] chip select on reads;
- [9] bus type;
- [10] idle cycle on bus type change.

Window g uses bits [g*11 +: 11] of the window configuration port.

Top module: `ebu_window_seq`

## Requirements
- R1: A window matches when it is enabled and addr_i[23:16] equals its 8-bit start value in every bit at or above the position given by its 3-bit size value (size s ignores the low s tag bits). The lowest-indexed matching window is used; with no match the default configuration applies.
- R2: The strobe (rd_o or wr_o) stays high for 1 + (15 - W) consecutive cycles, where W is bits [3:0] of the selected configuration.
- R3: ale_o is high for 1 cycle after acceptance. With bit [6] set it is high for 2 cycles and is followed by one address hold cycle before the strobe phase.
- R4: With bit [4] set, one extra cycle separates the address phase from the strobe.
- R5: With bit [5] set, the block stays busy (idle_o low) for one cycle after done_o before it returns to idle.
- R6: During the strobe, cs_o has bit g set only when window g was selected and bit [8] (reads) or bit [7] (writes) permits the direction. A default-configuration access, or a window whose mode excludes the direction, leaves cs_o all zero.
- R7: When bit [10] of the new configuration is set, one idle cycle is inserted before the address phase if bit [9] of the new configuration differs from bit [9] of the previously accepted access. The first access after reset never inserts this cycle.
- R8: wr_i=1 produces wr_o only and wr_i=0 produces rd_o only. done_o pulses for exactly one cycle, in the cycle right after the last strobe cycle.
- R9: A request is accepted only while idle_o is high. req_i and addr_i are ignored while busy, and addr_o keeps the accepted address for the whole access.
- R10: be_o equals the accepted byte enables while the strobe is high and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, taken when idle_o is high |
| addr_i | input | 24 | Access address |
| wr_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 2 | Byte enables |
| win_en_i | input | 4 | Per-window enable |
| win_start_i | input | 32 | Window start tags, 8 bits per window |
| win_size_i | input | 12 | Window size values, 3 bits per window |
| win_cfg_i | input | 44 | Window bus configurations, 11 bits per window |
| dflt_cfg_i | input | 11 | Default bus configuration |
| idle_o | output | 1 | Ready to accept a request |
| addr_o | output | 24 | Latched address of the current access |
| ale_o | output | 1 | Address latch strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| be_o | output | 2 | Byte enables, valid during the strobe |
| cs_o | output | 4 | Per-window chip selects |
| done_o | output | 1 | Cycle done pulse |

## Verification
A wrong window decision or an error in priority shows in the same access as a wrong chip-select bit and a wrong strobe length. A miscounted wait value stretches or shortens the strobe and moves done_o by the same number of cycles. A stale bus-type record only appears on the next access, as a missing or spurious idle cycle before the address latch strobe. For that reason the sequence alternates bus types and checks the busy length of every access.

// File: rtl/ebu_pkg.sv
package ebu_pkg;
  localparam int CFG_W = 11;

  typedef struct packed {
    logic       switch_idle;
    logic       bus_type;
    logic       cs_rd_en;
    logic       cs_wr_en;
    logic       ale_long;
    logic       tri_wait;
    logic       rw_delay;
    logic [3:0] wait_inv;
  } bcfg_t;

  typedef enum logic [3:0] {
    S_IDLE, S_SWITCH, S_ALE1, S_ALE2, S_HOLD, S_DLY, S_CMD, S_END, S_TRI
  } state_e;
endpackage

// File: rtl/ebu_win_match.sv
module ebu_win_match
  import ebu_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int TAG_W = 8,
  parameter int SZ_W  = 3,
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [TAG_W-1:0]      tag_i,
  input  logic [NWIN-1:0]       win_en_i,
  input  logic [NWIN*TAG_W-1:0] win_start_i,
  input  logic [NWIN*SZ_W-1:0]  win_size_i,
  input  logic [NWIN*CFG_W-1:0] win_cfg_i,
  input  bcfg_t                 dflt_cfg_i,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      idx_o,
  output bcfg_t                 cfg_o
);
  logic [NWIN-1:0] match;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [TAG_W-1:0] mask;
    assign mask     = {TAG_W{1'b1}} << win_size_i[g*SZ_W +: SZ_W];
    assign match[g] = win_en_i[g] &&
                      (((tag_i ^ win_start_i[g*TAG_W +: TAG_W]) & mask) == '0);
  end

  // lowest index wins: scan from the top so lower indices overwrite
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    cfg_o = dflt_cfg_i;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        cfg_o = bcfg_t'(win_cfg_i[i*CFG_W +: CFG_W]);
      end
    end
  end
endmodule

// File: rtl/ebu_cycle_fsm.sv
module ebu_cycle_fsm
  import ebu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  bcfg_t cfg_i,
  output logic  load_o,
  output logic  idle_o,
  output logic  ale_o,
  output logic  cmd_o,
  output logic  done_o,
  output logic  cs_wr_en_o,
  output logic  cs_rd_en_o
);
  state_e     state_q, state_d;
  logic [3:0] cnt_q, wait_q;
  logic       rwd_q, tri_q, alel_q, csw_q, csr_q, type_q, have_prev_q;
  logic       need_switch;

  assign load_o      = (state_q == S_IDLE) && req_i;
  assign need_switch = have_prev_q && cfg_i.switch_idle && (cfg_i.bus_type != type_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (req_i) state_d = need_switch ? S_SWITCH : S_ALE1;
      S_SWITCH: state_d = S_ALE1;
      S_ALE1:   state_d = alel_q ? S_ALE2 : (rwd_q ? S_DLY : S_CMD);
      S_ALE2:   state_d = S_HOLD;
      S_HOLD:   state_d = rwd_q ? S_DLY : S_CMD;
      S_DLY:    state_d = S_CMD;
      S_CMD:    if (cnt_q == 4'd0) state_d = S_END;
      S_END:    state_d = tri_q ? S_TRI : S_IDLE;
      S_TRI:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      wait_q      <= '0;
      rwd_q       <= 1'b0;
      tri_q       <= 1'b0;
      alel_q      <= 1'b0;
      csw_q       <= 1'b0;
      csr_q       <= 1'b0;
      type_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        wait_q      <= cfg_i.wait_inv;
        rwd_q       <= cfg_i.rw_delay;
        tri_q       <= cfg_i.tri_wait;
        alel_q      <= cfg_i.ale_long;
        csw_q       <= cfg_i.cs_wr_en;
        csr_q       <= cfg_i.cs_rd_en;
        type_q      <= cfg_i.bus_type;
        have_prev_q <= 1'b1;
      end
      // wait field is inverted: waits = 15 - field
      if (state_q != S_CMD && state_d == S_CMD) cnt_q <= 4'd15 - wait_q;
      else if (state_q == S_CMD && cnt_q != 4'd0) cnt_q <= cnt_q - 4'd1;
    end
  end

  assign idle_o     = (state_q == S_IDLE);
  assign ale_o      = (state_q == S_ALE1) || (state_q == S_ALE2);
  assign cmd_o      = (state_q == S_CMD);
  assign done_o     = (state_q == S_END);
  assign cs_wr_en_o = csw_q;
  assign cs_rd_en_o = csr_q;

  a_r8_done_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cmd_o));
  a_r5_end_not_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !cmd_o);
endmodule

// File: rtl/ebu_cs_gen.sv
module ebu_cs_gen #(
  parameter int NWIN = 4,
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wr_i,
  input  logic             cs_wr_en_i,
  input  logic             cs_rd_en_i,
  output logic [NWIN-1:0]  cs_o
);
  logic mode_ok;
  assign mode_ok = wr_i ? cs_wr_en_i : cs_rd_en_i;

  for (genvar g = 0; g < NWIN; g++) begin : g_cs
    assign cs_o[g] = cmd_i && hit_i && mode_ok && (idx_i == IDX_W'(g));
  end

  a_r6_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
endmodule

// File: rtl/ebu_window_seq.sv
module ebu_window_seq
  import ebu_pkg::*;
#(
  parameter int AW    = 24,
  parameter int BE_W  = 2,
  parameter int NWIN  = 4,
  parameter int TAG_W = 8,
  parameter int SZ_W  = 3,
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [AW-1:0]         addr_i,
  input  logic                  wr_i,
  input  logic [BE_W-1:0]       be_i,
  input  logic [NWIN-1:0]       win_en_i,
  input  logic [NWIN*TAG_W-1:0] win_start_i,
  input  logic [NWIN*SZ_W-1:0]  win_size_i,
  input  logic [NWIN*CFG_W-1:0] win_cfg_i,
  input  logic [CFG_W-1:0]      dflt_cfg_i,
  output logic                  idle_o,
  output logic [AW-1:0]         addr_o,
  output logic                  ale_o,
  output logic                  rd_o,
  output logic                  wr_o,
  output logic [BE_W-1:0]       be_o,
  output logic [NWIN-1:0]       cs_o,
  output logic                  done_o
);
  logic             hit, load, cmd, csw_en, csr_en;
  logic [IDX_W-1:0] idx;
  bcfg_t            sel_cfg;

  logic [AW-1:0]    addr_q;
  logic             wr_q, hit_q;
  logic [BE_W-1:0]  be_q;
  logic [IDX_W-1:0] idx_q;

  ebu_win_match #(.NWIN(NWIN), .TAG_W(TAG_W), .SZ_W(SZ_W)) u_match (
    .tag_i      (addr_i[AW-1 -: TAG_W]),
    .win_en_i   (win_en_i),
    .win_start_i(win_start_i),
    .win_size_i (win_size_i),
    .win_cfg_i  (win_cfg_i),
    .dflt_cfg_i (bcfg_t'(dflt_cfg_i)),
    .hit_o      (hit),
    .idx_o      (idx),
    .cfg_o      (sel_cfg)
  );

  ebu_cycle_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .cfg_i     (sel_cfg),
    .load_o    (load),
    .idle_o    (idle_o),
    .ale_o     (ale_o),
    .cmd_o     (cmd),
    .done_o    (done_o),
    .cs_wr_en_o(csw_en),
    .cs_rd_en_o(csr_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      be_q   <= '0;
      hit_q  <= 1'b0;
      idx_q  <= '0;
    end else if (load) begin
      addr_q <= addr_i;
      wr_q   <= wr_i;
      be_q   <= be_i;
      hit_q  <= hit;
      idx_q  <= idx;
    end
  end

  ebu_cs_gen #(.NWIN(NWIN)) u_cs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .hit_i     (hit_q),
    .idx_i     (idx_q),
    .wr_i      (wr_q),
    .cs_wr_en_i(csw_en),
    .cs_rd_en_i(csr_en),
    .cs_o      (cs_o)
  );

  assign addr_o = addr_q;
  assign rd_o   = cmd && !wr_q;
  assign wr_o   = cmd && wr_q;
  assign be_o   = cmd ? be_q : '0;

  a_r8_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  a_r6_cs_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cs_o) |-> (rd_o || wr_o));
  a_r9_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |=> $stable(addr_o));
  a_r10_be_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o || wr_o) |-> (be_o == '0));
  a_r3_ale_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !done_o);
endmodule

// File: tb/ebu_window_seq_tb_top.sv
module ebu_window_seq_tb_top;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] addr = '0;
  logic        wr = 1'b0;
  logic [1:0]  be = '0;
  logic [3:0]  win_en;
  logic [31:0] win_start;
  logic [11:0] win_size;
  logic [43:0] win_cfg;
  logic [10:0] dflt_cfg;
  logic        idle, ale, rd_s, wr_s, done;
  logic [23:0] addr_out;
  logic [1:0]  be_out;
  logic [3:0]  cs;

  always #5 clk = ~clk;

  ebu_window_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .wr_i(wr), .be_i(be),
    .win_en_i(win_en), .win_start_i(win_start), .win_size_i(win_size),
    .win_cfg_i(win_cfg), .dflt_cfg_i(dflt_cfg),
    .idle_o(idle), .addr_o(addr_out), .ale_o(ale), .rd_o(rd_s), .wr_o(wr_s),
    .be_o(be_out), .cs_o(cs), .done_o(done)
  );

  typedef struct {
    int          busy;
    int          ale_n;
    int          strobe;
    logic        is_wr;
    logic [3:0]  cs;
    int          post;
    logic [1:0]  be;
    logic [23:0] addr;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  logic have_prev = 1'b0;
  logic prev_type = 1'b0;

  function automatic logic [10:0] mk(input logic [3:0] w, input logic rwd, input logic tw,
                                     input logic al, input logic csw, input logic csr,
                                     input logic ty, input logic swi);
    return {swi, ty, csr, csw, al, tw, rwd, w};
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // driver: predicts from the requirements, pushes, then drives
  task automatic access(input logic [23:0] a, input logic w, input logic [1:0] b,
                        input bit hold_extra);
    logic [10:0] c;
    logic        hit;
    int          ix;
    logic [7:0]  tag, mask;
    exp_t        e;
    int          sw;
    hit = 1'b0; ix = 0; c = dflt_cfg; tag = a[23:16];
    for (int i = 0; i < NW; i++) begin
      mask = 8'hFF << win_size[i*3 +: 3];
      if (!hit && win_en[i] && (((tag ^ win_start[i*8 +: 8]) & mask) == 8'h00)) begin
        hit = 1'b1; ix = i; c = win_cfg[i*11 +: 11];
      end
    end
    sw = (have_prev && c[10] && (c[9] != prev_type)) ? 1 : 0;
    have_prev = 1'b1; prev_type = c[9];
    e.strobe = 1 + (15 - int'(c[3:0]));
    e.ale_n  = c[6] ? 2 : 1;
    e.busy   = sw + e.ale_n + (c[6] ? 1 : 0) + (c[4] ? 1 : 0) + e.strobe;
    e.is_wr  = w;
    e.cs     = (hit && (w ? c[7] : c[8])) ? (4'b0001 << ix) : 4'b0000;
    e.post   = c[5] ? 1 : 0;
    e.be     = b;
    e.addr   = a;
    @(negedge clk);
    while (!idle) @(negedge clk);
    q.push_back(e);
    req = 1'b1; addr = a; wr = w; be = b;
    @(negedge clk);
    if (hold_extra) begin
      addr = 24'h400000; wr = ~w; be = ~b;  // ignored while busy
      @(negedge clk);
    end
    req = 1'b0;
  endtask

  // monitor
  int   m_busy, m_post, m_ale, m_rd, m_wr, m_done, m_bebad;
  logic m_active = 1'b0, m_seen_done;
  logic [3:0]  m_cs;
  logic [1:0]  m_be;
  logic [23:0] m_addr;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!idle) begin
        if (!m_active) begin
          m_active = 1'b1; m_busy = 0; m_post = 0; m_ale = 0; m_rd = 0; m_wr = 0;
          m_done = 0; m_bebad = 0; m_cs = '0; m_be = '0; m_seen_done = 1'b0;
          m_addr = addr_out;
        end
        if (addr_out != m_addr) m_bebad++;
        if (done) begin m_done++; m_seen_done = 1'b1; end
        else if (m_seen_done) m_post++;
        else m_busy++;
        if (ale) m_ale++;
        if (rd_s) m_rd++;
        if (wr_s) m_wr++;
        if (rd_s || wr_s) begin m_cs = m_cs | cs; m_be = be_out; end
        else if (be_out != 2'b00 || cs != 4'b0000) m_bebad++;
      end else if (m_active) begin
        m_active = 1'b0;
        if (q.size() == 0) chk(1'b0, "R9 unexpected access", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(m_busy == e.busy, "R2/R4/R7 busy cycles before done", m_busy, e.busy);
          chk(m_ale == e.ale_n, "R3 ale cycles", m_ale, e.ale_n);
          chk((e.is_wr ? m_wr : m_rd) == e.strobe, "R2 strobe width",
              e.is_wr ? m_wr : m_rd, e.strobe);
          chk((e.is_wr ? m_rd : m_wr) == 0, "R8 wrong strobe kind",
              e.is_wr ? m_rd : m_wr, 0);
          chk(m_cs == e.cs, "R1/R6 chip select", int'(m_cs), int'(e.cs));
          chk(m_done == 1, "R8 done pulse count", m_done, 1);
          chk(m_post == e.post, "R5 tri-state cycles", m_post, e.post);
          chk(m_be == e.be, "R10 byte enables", int'(m_be), int'(e.be));
          chk(m_addr == e.addr && m_bebad == 0, "R9/R10 addr hold and quiet outputs",
              int'(m_addr), int'(e.addr));
        end
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    win_en    = 4'b0111;
    win_start = {8'h80, 8'h40, 8'h10, 8'h10};
    win_size  = {3'd0, 3'd2, 3'd4, 3'd0};
    win_cfg   = {mk(4'd15, 0, 0, 0, 1, 1, 0, 0),   // w3 disabled
                 mk(4'd14, 1, 1, 0, 1, 0, 1, 1),   // w2
                 mk(4'd12, 0, 0, 1, 0, 1, 0, 0),   // w1
                 mk(4'd15, 0, 0, 0, 1, 1, 0, 0)};  // w0
    dflt_cfg  = mk(4'd13, 0, 0, 0, 1, 1, 0, 1);
    repeat (3) @(negedge clk);
    chk(idle == 1'b1, "R9 reset idle", int'(idle), 1);
    chk({ale, rd_s, wr_s, done} == 4'b0000 && cs == 4'b0000 && be_out == 2'b00,
        "R8 reset outputs quiet", int'({ale, rd_s, wr_s, done}), 0);
    rst_n = 1'b1;
    access(24'h100004, 1'b0, 2'b01, 0);  // R1 priority w0 over w1
    access(24'h100008, 1'b1, 2'b10, 0);  // R6 w0 write
    access(24'h150000, 1'b0, 2'b11, 0);  // R3 long ale, R2 3 waits
    access(24'h150000, 1'b1, 2'b11, 0);  // R6 read-only window on write
    access(24'h410000, 1'b1, 2'b01, 0);  // R7 switch, R4, R5
    access(24'h420000, 1'b0, 2'b10, 0);  // R6 write-only window on read
    access(24'h800000, 1'b0, 2'b11, 0);  // R1 disabled window -> default, R7 switch
    access(24'h200000, 1'b0, 2'b01, 0);  // R7 same type, no switch
    access(24'h100000, 1'b1, 2'b01, 1);  // R9 busy request ignored
    access(24'h440000, 1'b1, 2'b10, 0);  // R1 just past w2
    access(24'h43FFFF, 1'b0, 2'b11, 0);  // R1 w2 upper edge, R7
    access(24'h1FFFFF, 1'b0, 2'b01, 0);  // R1 w1 upper edge
    @(negedge clk);
    while (!idle) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R8 all accesses completed", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule